// File: doc/BRIEF.md
# Pin Port Controller with Edge Interrupts

This block is a 32-pin general-purpose I/O port that sits on a simple word-wide register bus. The bus has an address, a write enable, write data and a combinational read-data return. Each pin has three settings held in registers: its direction, an open-drain enable and an output value. The block drives separate output and output-enable vectors towards the pads and receives a pad input vector.

Pad inputs are re-timed through a two-stage synchroniser. Each synchronised sample is then compared with the one before it to find edges. A per-pin selector chooses whether a pin records events on falling edges only or on either edge. Recorded events remain pending until software writes a one to them. A mask register selects which pending events contribute to the single interrupt output.

Pin numbering is reversed against bit numbering, so pin 0 is the most significant bit of every register. A parameter declares the highest-numbered pins to be input-only. By default these are the four pins 28 to 31, and their direction bits can never enable a pad driver.

Top module: `pin_port_ctrl`

## Requirements
- R1: After reset every register reads back zero, no pad output enable is set and the interrupt output is low.
- R2: Register byte offsets are 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge select. Any other address, including a misaligned one, reads zero and a write to it changes no register.
- R3: Pin n is register bit (31 - n) in every register and in the pad vectors, so pin 0 is bit 31.
- R4: A direction bit of 1 makes the pin an output and 0 makes it an input. A push-pull output pin (open-drain bit 0) has its pad enable set and drives its data bit.
- R5: An output pin with its open-drain bit at 1 enables its pad and drives low when its data bit is 0. When its data bit is 1 it releases the pad (enable 0), and it never drives high.
- R6: Reading the data offset returns the stored data bit for output pins and the synchronised pad sample for input pins.
- R7: A pad input change is visible in the data readback after the second rising clock edge. It is recorded in the event register at the third rising clock edge after it is applied.
- R8: An edge-select bit of 1 records falling edges only. A bit of 0 records both rising and falling edges.
- R9: Writing to the event offset clears each bit written as 1 and leaves each bit written as 0 unchanged. Event bits are otherwise sticky.
- R10: When a new edge and a clearing write reach the same event bit in the same cycle, the bit stays set.
- R11: The interrupt output is high exactly when some event bit and its mask bit (1 = enabled) are both 1.
- R12: With the default parameters, pins 28 to 31 are input-only. Their direction bits (bits 3 to 0) read as 0 regardless of writes, and their pad enables stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W (5) | Byte address of the register accessed |
| busWe | input | 1 | Write enable for the addressed register |
| busWdata | input | NUM_PINS (32) | Write data |
| busRdata | output | NUM_PINS (32) | Read data for busAddr, combinational |
| padIn | input | NUM_PINS (32) | Pad input levels, asynchronous |
| padOut | output | NUM_PINS (32) | Pad output levels |
| padOe | output | NUM_PINS (32) | Pad output enables |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A synchronised edge and a software clear can reach the same event bit on the same clock edge. The bench provokes this by toggling a pin that already has a pending event. It then times an event-register write of ones so that the write strobe is active on exactly the third rising edge after the toggle, which is when the detector reports the new edge. The event bit must still read one afterwards, and a second bit cleared by the same write must read zero. A behavioural reference model also tracks every cycle, so any disagreement in readback, pads or interrupt during that window is reported as well.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

  // Byte offsets of the registers on the bus
  localparam int OFF_DIR  = 'h00;
  localparam int OFF_OD   = 'h04;
  localparam int OFF_DATA = 'h08;
  localparam int OFF_EVT  = 'h0C;
  localparam int OFF_MASK = 'h10;
  localparam int OFF_EDGE = 'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_OD,
    SEL_DATA,
    SEL_EVT,
    SEL_MASK,
    SEL_EDGE,
    SEL_NONE
  } regSel_t;

  // Write strobes from control to datapath
  typedef struct packed {
    logic dir;
    logic od;
    logic data;
    logic evtClr;
    logic mask;
    logic edgeSel;
  } wrStrobes_t;

endpackage

// File: rtl/pin_port_ctrl_path.sv
module pin_port_ctrl_path
  import pin_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output wrStrobes_t        wr,
  output regSel_t           rdSel
);

  // Full-address compare: misaligned or unmapped addresses select nothing
  always_comb begin
    if      (busAddr == ADDR_W'(OFF_DIR))  rdSel = SEL_DIR;
    else if (busAddr == ADDR_W'(OFF_OD))   rdSel = SEL_OD;
    else if (busAddr == ADDR_W'(OFF_DATA)) rdSel = SEL_DATA;
    else if (busAddr == ADDR_W'(OFF_EVT))  rdSel = SEL_EVT;
    else if (busAddr == ADDR_W'(OFF_MASK)) rdSel = SEL_MASK;
    else if (busAddr == ADDR_W'(OFF_EDGE)) rdSel = SEL_EDGE;
    else                                   rdSel = SEL_NONE;
  end

  always_comb begin
    wr = '0;
    if (busWe) begin
      case (rdSel)
        SEL_DIR:  wr.dir     = 1'b1;
        SEL_OD:   wr.od      = 1'b1;
        SEL_DATA: wr.data    = 1'b1;
        SEL_EVT:  wr.evtClr  = 1'b1;
        SEL_MASK: wr.mask    = 1'b1;
        SEL_EDGE: wr.edgeSel = 1'b1;
        default:  wr         = '0;
      endcase
    end
  end

endmodule

// File: rtl/pin_port_data_path.sv
module pin_port_data_path
  import pin_port_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int INPUT_ONLY = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobes_t          wr,
  input  regSel_t             rdSel,
  input  logic [NUM_PINS-1:0] busWdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] busRdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irq,
  output logic [NUM_PINS-1:0] evtReg,
  output logic [NUM_PINS-1:0] maskReg,
  output logic [NUM_PINS-1:0] odReg,
  output logic [NUM_PINS-1:0] edgeReg,
  output logic [NUM_PINS-1:0] syncCur,
  output logic [NUM_PINS-1:0] syncPrev
);

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] dataReg;
  logic [NUM_PINS-1:0] syncMeta;
  logic [NUM_PINS-1:0] dirWritable;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] clrBits;

  // Per-pin structure: writability of direction, pad drive, edge detect.
  // Highest-numbered pins sit in the lowest bits.
  for (genvar b = 0; b < NUM_PINS; b++) begin : g_pin
    if (b < INPUT_ONLY) begin : g_inOnly
      assign dirWritable[b] = 1'b0;
    end else begin : g_bidir
      assign dirWritable[b] = 1'b1;
    end
    assign padOe[b]   = dirReg[b] & ~(odReg[b] & dataReg[b]);
    assign padOut[b]  = dataReg[b] & ~odReg[b];
    assign edgeHit[b] = (syncPrev[b] & ~syncCur[b])
                      | (~edgeReg[b] & syncCur[b] & ~syncPrev[b]);
  end

  assign clrBits = wr.evtClr ? busWdata : '0;

  // Synchroniser and previous-sample stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= '0;
      syncCur  <= '0;
      syncPrev <= '0;
    end else begin
      syncMeta <= padIn;
      syncCur  <= syncMeta;
      syncPrev <= syncCur;
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      odReg   <= '0;
      dataReg <= '0;
      maskReg <= '0;
      edgeReg <= '0;
    end else begin
      if (wr.dir)     dirReg  <= busWdata & dirWritable;
      if (wr.od)      odReg   <= busWdata;
      if (wr.data)    dataReg <= busWdata;
      if (wr.mask)    maskReg <= busWdata;
      if (wr.edgeSel) edgeReg <= busWdata;
    end
  end

  // Sticky events: a fresh edge outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtReg <= '0;
    else       evtReg <= (evtReg & ~clrBits) | edgeHit;
  end

  assign irq = |(evtReg & maskReg);

  always_comb begin
    case (rdSel)
      SEL_DIR:  busRdata = dirReg;
      SEL_OD:   busRdata = odReg;
      SEL_DATA: busRdata = (dataReg & dirReg) | (syncCur & ~dirReg);
      SEL_EVT:  busRdata = evtReg;
      SEL_MASK: busRdata = maskReg;
      SEL_EDGE: busRdata = edgeReg;
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import pin_port_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int ADDR_W     = 5,
  parameter int INPUT_ONLY = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irq
);

  wrStrobes_t          wr;
  regSel_t             rdSel;
  logic [NUM_PINS-1:0] evtReg;
  logic [NUM_PINS-1:0] maskReg;
  logic [NUM_PINS-1:0] odReg;
  logic [NUM_PINS-1:0] edgeReg;
  logic [NUM_PINS-1:0] syncCur;
  logic [NUM_PINS-1:0] syncPrev;

  pin_port_ctrl_path #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .wr      (wr),
    .rdSel   (rdSel)
  );

  pin_port_data_path #(.NUM_PINS(NUM_PINS), .INPUT_ONLY(INPUT_ONLY)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .wr       (wr),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .padIn    (padIn),
    .busRdata (busRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .irq      (irq),
    .evtReg   (evtReg),
    .maskReg  (maskReg),
    .odReg    (odReg),
    .edgeReg  (edgeReg),
    .syncCur  (syncCur),
    .syncPrev (syncPrev)
  );

endmodule

// File: rtl/pin_port_ctrl_chk.sv
module pin_port_ctrl_chk
  import pin_port_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int ADDR_W     = 5,
  parameter int INPUT_ONLY = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irq,
  input logic [NUM_PINS-1:0] evtReg,
  input logic [NUM_PINS-1:0] maskReg,
  input logic [NUM_PINS-1:0] odReg,
  input logic [NUM_PINS-1:0] edgeReg,
  input logic [NUM_PINS-1:0] syncCur,
  input logic [NUM_PINS-1:0] syncPrev
);

  localparam logic [NUM_PINS-1:0] IN_ONLY_MASK =
    NUM_PINS'((64'(1) << INPUT_ONLY) - 64'(1));

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && !irq));

  a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & odReg) == '0);

  a_r7_event_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    (evtReg & ~$past(evtReg) & ~$past(syncCur ^ syncPrev)) == '0);

  a_r8_no_rise_when_fall_only: assert property (@(posedge clk) disable iff (!rstN)
    (evtReg & ~$past(evtReg) & $past(edgeReg & syncCur & ~syncPrev)) == '0);

  a_r9_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    ((~evtReg & $past(evtReg)) != '0) |-> $past(busWe && busAddr == ADDR_W'(OFF_EVT)));

  a_r11_masked_silent: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irq);

  a_r12_input_only_undriven: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & IN_ONLY_MASK) == '0);

endmodule

bind pin_port_ctrl pin_port_ctrl_chk #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .INPUT_ONLY (INPUT_ONLY)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .padOut   (padOut),
  .padOe    (padOe),
  .irq      (irq),
  .evtReg   (evtReg),
  .maskReg  (maskReg),
  .odReg    (odReg),
  .edgeReg  (edgeReg),
  .syncCur  (syncCur),
  .syncPrev (syncPrev)
);

// File: tb/pin_port_ctrl_tb.sv
module pin_port_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_port_ctrl u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .irq      (irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mDir, mOd, mData, mEvt, mMask, mEdge;
  logic [31:0] seen[$];   // seen[0] newest pad sample, seen[1] synchronised, seen[2] previous
  logic [31:0] mHit, mClr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir = 0; mOd = 0; mData = 0; mEvt = 0; mMask = 0; mEdge = 0;
      seen = '{32'h0, 32'h0, 32'h0};
    end else begin
      mHit = 0;
      for (int p = 0; p < 32; p++) begin
        int b;
        b = 31 - p;
        if (seen[2][b] && !seen[1][b]) mHit[b] = 1'b1;
        if (!seen[2][b] && seen[1][b] && !mEdge[b]) mHit[b] = 1'b1;
      end
      mClr = (busWe && busAddr == 5'h0C) ? busWdata : 32'h0;
      mEvt = (mEvt & ~mClr) | mHit;
      if (busWe) begin
        case (busAddr)
          5'h00: mDir  = busWdata & 32'hFFFF_FFF0;
          5'h04: mOd   = busWdata;
          5'h08: mData = busWdata;
          5'h10: mMask = busWdata;
          5'h14: mEdge = busWdata;
          default: ;
        endcase
      end
      seen.push_front(padIn);
      void'(seen.pop_back());
    end
  end

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    case (a)
      5'h00: return mDir;
      5'h04: return mOd;
      5'h08: return (mData & mDir) | (seen[1] & ~mDir);
      5'h0C: return mEvt;
      5'h10: return mMask;
      5'h14: return mEdge;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] modelOe();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[31-p] = mDir[31-p] && (!mOd[31-p] || !mData[31-p]);
    return r;
  endfunction

  function automatic logic [31:0] modelOut();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[31-p] = mOd[31-p] ? 1'b0 : mData[31-p];
    return r;
  endfunction

  task automatic checkVal(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #3;
    if (rstN && !done) begin
      checkVal(busRdata, modelRead(busAddr), "R6 model readback");
      checkVal(padOe, modelOe(), "R4 model pad enable");
      checkVal(padOut, modelOut(), "R5 model pad level");
      checkVal({31'h0, irq}, {31'h0, |(mEvt & mMask)}, "R11 model irq");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic expectReg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #3;
    checkVal(busRdata, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

  initial begin
    idle(3);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 24; a += 4) expectReg(5'(a), 32'h0, "R1 reset value");
    checkVal(padOe, 32'h0, "R1 pad enable after reset");
    checkVal({31'h0, irq}, 32'h0, "R1 irq after reset");

    // R12 / R4 / R3: directions, push-pull drive, bit order
    busWrite(5'h00, 32'hFFFF_FFFF);
    expectReg(5'h00, 32'hFFFF_FFF0, "R12 input-only direction bits");
    busWrite(5'h08, 32'h8000_0001);
    idle(1); #3;
    checkVal(padOe, 32'hFFFF_FFF0, "R4 push-pull enables");
    checkVal(padOut, 32'h8000_0001, "R4 push-pull levels");
    checkVal({31'h0, padOut[31]}, 32'h1, "R3 pin 0 is bit 31");

    // R5: open-drain
    busWrite(5'h04, 32'hFF00_0000);
    busWrite(5'h08, 32'h0F00_0000);
    idle(1); #3;
    checkVal(padOe, 32'hF0FF_FFF0, "R5 open-drain enables");
    checkVal(padOut, 32'h0000_0000, "R5 open-drain levels");
    busWrite(5'h04, 32'h0);

    // R6: data readback mixes stored and sampled bits
    busWrite(5'h00, 32'hFFFF_0000);
    busWrite(5'h08, 32'hAAAA_5555);
    @(negedge clk) padIn = 32'h1234_5678;
    idle(3);
    expectReg(5'h08, 32'hAAAA_5678, "R6 mixed data readback");

    // Prepare for events: all inputs, clear pending
    busWrite(5'h00, 32'h0);
    idle(2);
    busWrite(5'h0C, 32'hFFFF_FFFF);
    expectReg(5'h0C, 32'h0, "R9 clear all");

    // R7: event latency of three rising edges
    @(negedge clk);
    padIn = padIn | 32'h1; busAddr = 5'h0C;
    @(negedge clk); #3 checkVal(busRdata, 32'h0, "R7 no event after edge 1");
    @(negedge clk); #3 checkVal(busRdata, 32'h0, "R7 no event after edge 2");
    @(negedge clk); #3 checkVal(busRdata, 32'h1, "R7 event after edge 3");

    // R8: falling-only on pin 30 (bit 1)
    busWrite(5'h14, 32'h0000_0002);
    busWrite(5'h0C, 32'hFFFF_FFFF);
    @(negedge clk) padIn = padIn | 32'h2;
    idle(4);
    expectReg(5'h0C, 32'h0, "R8 rise ignored in fall-only mode");
    @(negedge clk) padIn = padIn & ~32'h3;
    idle(4);
    expectReg(5'h0C, 32'h3, "R8 fall recorded, any-edge fall recorded");

    // R9: write-one-to-clear
    busWrite(5'h0C, 32'h0000_0002);
    expectReg(5'h0C, 32'h1, "R9 selective clear");

    // R11: masking
    busWrite(5'h10, 32'h0);
    idle(1); #3 checkVal({31'h0, irq}, 32'h0, "R11 masked event");
    busWrite(5'h10, 32'h1);
    idle(1); #3 checkVal({31'h0, irq}, 32'h1, "R11 enabled event");
    busWrite(5'h10, 32'h2);
    idle(1); #3 checkVal({31'h0, irq}, 32'h0, "R11 other pin enabled");

    // R10: edge and clear collide on bit 2
    @(negedge clk) padIn = padIn | 32'h4;
    idle(4);
    expectReg(5'h0C, 32'h5, "R10 setup events");
    @(negedge clk) padIn = padIn & ~32'h4;
    @(negedge clk);
    @(negedge clk) begin busWe = 1'b1; busAddr = 5'h0C; busWdata = 32'h5; end
    @(negedge clk) busWe = 1'b0;
    #3 checkVal(busRdata, 32'h4, "R10 new edge beats clear");

    // R2: unmapped and misaligned addresses
    busWrite(5'h18, 32'hFFFF_FFFF);
    expectReg(5'h18, 32'h0, "R2 unmapped reads zero");
    expectReg(5'h01, 32'h0, "R2 misaligned reads zero");
    expectReg(5'h10, 32'h2, "R2 mask untouched by unmapped write");
    expectReg(5'h14, 32'h2, "R2 edge select at offset 0x14");

    idle(2);
    finishRun();
  end

endmodule